// File: doc/BRIEF.md
# Sample Capture Buffer Controller

This block gathers converter samples into a small on-chip history of sixteen 16-bit words. Each sample reaches it as a 12-bit result, a channel number and a valid strobe. The block turns each accepted sample into one stored word. The layout of that word depends on a format select: the word carries the bare result, or the result with the channel number, or the result with the channel number and a set data-valid bit.

A three-bit mode input controls when samples are stored. In halt mode nothing is written. In fill mode the buffer takes samples until it is full. In history mode the buffer runs as a ring that keeps the latest sixteen samples and freezes when the alert input fires. In after-alert mode the buffer waits for the alert and then records the next sixteen samples. The alert comes from a detector outside the block.

The read side pops one word at a time. The oldest word is always shown on `rd_data`, and a live fill count is available as an output. A consumer that reads only whole bursts can use the count to decide when to drain the buffer.

Top module: `capbuf_ctrl`

## Requirements
- R1: After synchronous reset, `fill_count` is 0 and `rd_data` is 0.
- R2: `fill_count` is a 5-bit value in the range 0 to 16. It rises by one for each stored sample and falls by one for each successful pop. When a store and a pop happen in the same cycle, the count does not change.
- R3: With format code 00 or 11 on `cfg_fmt`, the stored word is `{result[11:0], 4'b0000}`. The format is applied at the moment the sample is stored.
- R4: With format code 01, the stored word is `{result[11:0], chid[2:0], 1'b0}`. Channel 0 is encoded as 000 and channel 1 as 001.
- R5: With format code 10, the stored word is `{result[11:0], chid[2:0], 1'b1}`. Bit 0 is the data-valid flag.
- R6: `rd_data` shows the oldest stored word without a read request. A cycle with `rd_en` high removes that word, so words leave in arrival order.
- R7: When the buffer is empty, `rd_data` is 0, and a read request leaves the count at 0.
- R8: With `cfg_mode` 000, and with any code other than 001, 100 or 110, no sample is stored.
- R9: With `cfg_mode` 001, samples are stored until the count reaches 16. Later samples are dropped and the stored contents do not change.
- R10: With `cfg_mode` 100 and alert not yet seen, every valid sample is stored. When the buffer is full and no read happens in that cycle, the new sample replaces the oldest one and the count stays at 16.
- R11: In mode 100, no sample is stored from the cycle in which `alert_in` is high onward. This includes a sample that arrives in that same cycle. The freeze lasts until the mode changes.
- R12: With `cfg_mode` 110, no sample is stored before the alert. The sample that arrives in the alert cycle and the samples after it are stored until the count reaches 16.
- R13: Any change of `cfg_mode` clears the remembered alert, so returning to mode 100 resumes storing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_result | input | 12 | Conversion result |
| smp_chid | input | 3 | Channel number of the sample |
| alert_in | input | 1 | Alert from the external detector |
| cfg_mode | input | 3 | Capture mode: 000 halt, 001 fill, 100 history, 110 after-alert |
| cfg_fmt | input | 2 | Stored word layout select |
| rd_en | input | 1 | Pop the oldest word |
| rd_data | output | 16 | Oldest stored word, or 0 when empty |
| fill_count | output | 5 | Number of stored words |

## Verification
The bench aims at the full boundary. A store into a full buffer in fill or after-alert mode must be dropped rather than wrap, and in history mode it must overwrite. A design that confused these cases would show a wrong head word or a count of 0 or 17.

The bench also puts a sample in the exact cycle the alert rises. A design that evaluated the alert one cycle late would keep an extra word in history mode, or lose the first word in after-alert mode.

Stores and pops in the same cycle, and reads of an empty buffer, are checked to catch a count that drifts or wraps below zero. A mode change between two history runs is checked to catch a freeze that never releases.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int RES_W     = 12;
    localparam int ID_W      = 3;
    localparam int WORD_W    = RES_W + ID_W + 1;
    localparam int CAP_DEPTH = 16;

    localparam logic [2:0] MODE_HALT  = 3'b000;
    localparam logic [2:0] MODE_FILL  = 3'b001;
    localparam logic [2:0] MODE_HIST  = 3'b100;
    localparam logic [2:0] MODE_AFTER = 3'b110;

    typedef enum logic [1:0] {
        FMT_BARE    = 2'b00,
        FMT_CHAN    = 2'b01,
        FMT_CHAN_DV = 2'b10,
        FMT_BARE_B  = 2'b11
    } fmt_e;

    typedef struct packed {
        logic [RES_W-1:0] res;
        logic [ID_W-1:0]  id;
    } sample_t;

    typedef struct packed {
        logic push;
        logic overwrite;
    } wr_ctl_t;

    function automatic logic [WORD_W-1:0] pack_word(sample_t s, fmt_e f);
        logic [WORD_W-1:0] w;
        case (f)
            FMT_CHAN:    w = {s.res, s.id, 1'b0};
            FMT_CHAN_DV: w = {s.res, s.id, 1'b1};
            default:     w = {s.res, {(ID_W+1){1'b0}}};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/capbuf_mode_ctl.sv
module capbuf_mode_ctl
    import cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] cfg_mode,
    input  logic       alert_in,
    input  logic       smp_valid,
    input  logic       full,
    input  logic       rd_pop,
    output wr_ctl_t    ctl
);

    logic [2:0] mode_q;
    logic       trig_q;
    logic       mode_chg;
    logic       trig_eff;
    logic       alert_mode;

    always_comb begin
        mode_chg   = (cfg_mode != mode_q);
        trig_eff   = (trig_q && !mode_chg) || alert_in;
        alert_mode = (cfg_mode == MODE_HIST) || (cfg_mode == MODE_AFTER);
        ctl        = '0;
        case (cfg_mode)
            MODE_FILL: ctl.push = smp_valid && !full;
            MODE_HIST: begin
                ctl.push      = smp_valid && !trig_eff;
                ctl.overwrite = smp_valid && !trig_eff && full && !rd_pop;
            end
            MODE_AFTER: ctl.push = smp_valid && trig_eff && !full;
            default:    ctl = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_FILL;
            trig_q <= 1'b0;
        end else begin
            mode_q <= cfg_mode;
            trig_q <= alert_mode && trig_eff;
        end
    end

    AST_FROZEN_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
        (trig_q && cfg_mode == MODE_HIST && cfg_mode == mode_q) |-> !ctl.push); // R11

    AST_AFTER_WAITS: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == MODE_AFTER && !alert_in && !trig_q) |-> !ctl.push); // R12

endmodule

// File: rtl/capbuf_store.sv
module capbuf_store #(
    parameter  int DEPTH  = 16,
    parameter  int WORD_W = 16,
    localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              overwrite,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_en,
    output logic              rd_pop,
    output logic              full,
    output logic [WORD_W-1:0] rd_data,
    output logic [CW-1:0]     fill
);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic              drop_head;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        full      = (fill == CW'(DEPTH));
        rd_pop    = rd_en && (fill != '0);
        drop_head = rd_pop || overwrite;
        rd_data   = (fill == '0) ? '0 : mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push)      wr_ptr <= bump(wr_ptr);
            if (drop_head) rd_ptr <= bump(rd_ptr);
            fill <= fill + CW'(push) - CW'(drop_head);
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        fill <= CW'(DEPTH)); // R2

    AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (fill == '0 && !push) |=> (fill == '0)); // R7

    AST_FULL_STAYS: assert property (@(posedge clk) disable iff (rst)
        (fill == CW'(DEPTH) && !rd_en) |=> (fill == CW'(DEPTH))); // R9

    AST_OVERWRITE_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
        overwrite |-> (fill == CW'(DEPTH) && push)); // R10

endmodule

// File: rtl/capbuf_ctrl.sv
module capbuf_ctrl
    import cap_pkg::*;
#(
    parameter  int DEPTH = CAP_DEPTH,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [RES_W-1:0]  smp_result,
    input  logic [ID_W-1:0]   smp_chid,
    input  logic              alert_in,
    input  logic [2:0]        cfg_mode,
    input  logic [1:0]        cfg_fmt,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic [CW-1:0]     fill_count
);

    sample_t           smp;
    logic [WORD_W-1:0] wr_word;
    wr_ctl_t           ctl;
    logic              full;
    logic              rd_pop;

    always_comb begin
        smp.res = smp_result;
        smp.id  = smp_chid;
        wr_word = pack_word(smp, fmt_e'(cfg_fmt));
    end

    capbuf_mode_ctl u_mode (
        .clk       (clk),
        .rst       (rst),
        .cfg_mode  (cfg_mode),
        .alert_in  (alert_in),
        .smp_valid (smp_valid),
        .full      (full),
        .rd_pop    (rd_pop),
        .ctl       (ctl)
    );

    capbuf_store #(
        .DEPTH  (DEPTH),
        .WORD_W (WORD_W)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .push      (ctl.push),
        .overwrite (ctl.overwrite),
        .wr_word   (wr_word),
        .rd_en     (rd_en),
        .rd_pop    (rd_pop),
        .full      (full),
        .rd_data   (rd_data),
        .fill      (fill_count)
    );

    AST_HALT_NO_GROWTH: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == MODE_HALT) |=> (fill_count <= $past(fill_count))); // R8

endmodule

// File: tb/capbuf_ctrl_tb.sv
module capbuf_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_result = '0;
    logic [2:0]  smp_chid = '0;
    logic        alert_in = 1'b0;
    logic [2:0]  cfg_mode = 3'b001;
    logic [1:0]  cfg_fmt = 2'b00;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic [4:0]  fill_count;

    logic [2:0]  want_mode = 3'b001;
    logic [1:0]  want_fmt  = 2'b00;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;
    string tag = "R1";

    logic [15:0] mq[$];
    bit          trig_m;
    logic [2:0]  mprev;

    always #10 clk = ~clk;

    capbuf_ctrl u_dut (
        .clk        (clk),
        .rst        (rst),
        .smp_valid  (smp_valid),
        .smp_result (smp_result),
        .smp_chid   (smp_chid),
        .alert_in   (alert_in),
        .cfg_mode   (cfg_mode),
        .cfg_fmt    (cfg_fmt),
        .rd_en      (rd_en),
        .rd_data    (rd_data),
        .fill_count (fill_count)
    );

    task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", t, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_word(logic [11:0] r, logic [2:0] id, logic [1:0] f);
        int w;
        w = int'(r) * 16;
        if (f == 2'b01) w = w + int'(id) * 2;
        if (f == 2'b10) w = w + int'(id) * 2 + 1;
        return w[15:0];
    endfunction

    task automatic model_step(logic v, logic [11:0] r, logic [2:0] id, logic al, logic rd);
        int  sz;
        bit  rd_ok, chg, teff, push, ovw, amode;
        sz    = mq.size();
        rd_ok = rd && sz > 0;
        chg   = (cfg_mode != mprev);
        teff  = (trig_m && !chg) || al;
        amode = (cfg_mode == 3'b100) || (cfg_mode == 3'b110);
        push  = 0;
        ovw   = 0;
        if (cfg_mode == 3'b001) push = v && sz < 16;
        else if (cfg_mode == 3'b100) begin
            push = v && !teff;
            ovw  = push && sz == 16 && !rd_ok;
        end else if (cfg_mode == 3'b110) push = v && teff && sz < 16;
        if (rd_ok) void'(mq.pop_front());
        if (ovw)   void'(mq.pop_front());
        if (push)  mq.push_back(ref_word(r, id, cfg_fmt));
        trig_m = amode && teff;
        mprev  = cfg_mode;
    endtask

    task automatic compare_now();
        chk({tag, " count"}, 32'(fill_count), 32'(mq.size()));
        chk({tag, " word"}, 32'(rd_data), (mq.size() > 0) ? 32'(mq[0]) : 32'd0);
    endtask

    task automatic drive(logic v, logic [11:0] r, logic [2:0] id, logic al, logic rd);
        smp_valid  = v;
        smp_result = r;
        smp_chid   = id;
        alert_in   = al;
        rd_en      = rd;
        cfg_mode   = want_mode;
        cfg_fmt    = want_fmt;
        model_step(v, r, id, al, rd);
    endtask

    task automatic cyc(logic v, logic [11:0] r, logic [2:0] id, logic al, logic rd);
        @(negedge clk);
        compare_now();
        drive(v, r, id, al, rd);
    endtask

    task automatic hold_check(string t, int exp_cnt, logic [15:0] exp_word);
        @(negedge clk);
        compare_now();
        chk({t, " count literal"}, 32'(fill_count), 32'(exp_cnt));
        chk({t, " word literal"}, 32'(rd_data), 32'(exp_word));
        drive(0, '0, '0, 0, 0);
    endtask

    task automatic drain(int n);
        for (int i = 0; i < n; i++) cyc(0, '0, '0, 0, 1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        mq.delete();
        trig_m = 0;
        mprev  = 3'b001;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 count", 32'(fill_count), 32'd0);
        chk("R1 word", 32'(rd_data), 32'd0);

        // R3 R6: bare format, arrival order
        tag = "R6";
        for (int i = 0; i < 5; i++) cyc(1, 12'h0A0 + 12'(i * 37), 3'(i % 2), 0, 0);
        hold_check("R3", 5, 16'h0A00);
        drain(5);

        // R4, R5, R3 explicit layouts
        tag = "R4"; want_fmt = 2'b01;
        cyc(1, 12'h123, 3'd1, 0, 0);
        hold_check("R4", 1, 16'h1232);
        cyc(0, '0, '0, 0, 1);
        tag = "R5"; want_fmt = 2'b10;
        cyc(1, 12'h456, 3'd1, 0, 0);
        hold_check("R5", 1, 16'h4563);
        cyc(0, '0, '0, 0, 1);
        tag = "R3"; want_fmt = 2'b11;
        cyc(1, 12'hABC, 3'd1, 0, 0);
        hold_check("R3", 1, 16'hABC0);
        cyc(0, '0, '0, 0, 1);
        want_fmt = 2'b00;
        cyc(1, 12'hFFF, 3'd0, 0, 0);
        hold_check("R3", 1, 16'hFFF0);
        cyc(0, '0, '0, 0, 1);
        // mixed formats word by word
        tag = "R5";
        for (int i = 0; i < 8; i++) begin
            want_fmt = 2'(i % 4);
            cyc(1, 12'h700 + 12'(i), 3'(i % 2), 0, 0);
        end
        want_fmt = 2'b00;
        drain(8);

        // R7: reads of an empty buffer
        tag = "R7";
        for (int i = 0; i < 3; i++) cyc(0, '0, '0, 0, 1);
        hold_check("R7", 0, 16'h0000);

        // R2: simultaneous store and pop
        tag = "R2";
        for (int i = 0; i < 3; i++) cyc(1, 12'h050 + 12'(i), 3'd0, 0, 0);
        for (int i = 0; i < 4; i++) cyc(1, 12'h060 + 12'(i), 3'd1, 0, 1);
        hold_check("R2", 3, 16'h0610);
        drain(3);

        // R9: fill mode stops at 16
        tag = "R9";
        for (int i = 0; i < 20; i++) cyc(1, 12'h100 + 12'(i), 3'd0, 0, 0);
        hold_check("R9", 16, 16'h1000);
        drain(16);

        // R8: halt and a reserved code store nothing
        tag = "R8"; want_mode = 3'b000;
        for (int i = 0; i < 5; i++) cyc(1, 12'h0F0 + 12'(i), 3'd0, 0, 0);
        hold_check("R8", 0, 16'h0000);
        want_mode = 3'b010;
        for (int i = 0; i < 3; i++) cyc(1, 12'h0E0 + 12'(i), 3'd0, 0, 0);
        hold_check("R8", 0, 16'h0000);

        // R10: history ring overwrites oldest
        tag = "R10"; want_mode = 3'b100;
        for (int i = 0; i < 24; i++) cyc(1, 12'h200 + 12'(i), 3'd0, 0, 0);
        hold_check("R10", 16, 16'h2080);
        // R11: alert freezes, including the sample in the alert cycle
        tag = "R11";
        cyc(1, 12'h2F0, 3'd1, 1, 0);
        for (int i = 0; i < 5; i++) cyc(1, 12'h2E0 + 12'(i), 3'd1, 0, 0);
        hold_check("R11", 16, 16'h2080);
        drain(16);
        cyc(1, 12'h2D0, 3'd0, 0, 0);
        cyc(1, 12'h2D1, 3'd0, 0, 0);
        hold_check("R11", 0, 16'h0000);

        // R13: leaving and re-entering history mode releases the freeze
        tag = "R13"; want_mode = 3'b001;
        cyc(0, '0, '0, 0, 0);
        want_mode = 3'b100;
        cyc(1, 12'h250, 3'd0, 0, 0);
        cyc(1, 12'h251, 3'd0, 0, 0);
        hold_check("R13", 2, 16'h2500);
        drain(2);

        // R12: after-alert capture
        tag = "R12"; want_mode = 3'b110;
        for (int i = 0; i < 4; i++) cyc(1, 12'h3F0 + 12'(i), 3'd0, 0, 0);
        hold_check("R12", 0, 16'h0000);
        cyc(1, 12'h300, 3'd1, 1, 0);
        for (int i = 1; i < 20; i++) cyc(1, 12'h300 + 12'(i), 3'd1, 0, 0);
        hold_check("R12", 16, 16'h3000);
        drain(16);
        hold_check("R12", 0, 16'h0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule